// File: doc/BRIEF.md
# Indexed Framebuffer Control Register File

This block is the software-visible register file of an 8-bit indexed framebuffer controller. A host reaches it over a simple request bus (valid, write, size, byte address, data) and uses it to load a 256-entry colour lookup table, a 3-entry cursor colour table, a 512-entry cursor bitmap, the cursor position, the control word, the scan-out start offset and the display dimensions. Lookup tables sit on an 8-byte stride. Each colour entry is packed as 24-bit RGB.

The scan-out pipeline reads the stored tables through combinational lookup ports. It also receives the decoded control fields: blanking, cursor disable, pixel depth, and whether that depth can be displayed. The pipeline reports a finished frame on `frame_done`, which raises `irq`. Any host write drops `irq` again. Byte and halfword writes are merged into the current word by a read-modify-write sequence.

The sequencer has three states. `S_IDLE` accepts requests. `S_RESP` drives one cycle of read data. `S_MERGE` commits a merged sub-word write. The transitions are:
- IDLE→RESP on an accepted read.
- IDLE→MERGE on an accepted byte or halfword write.
- IDLE→IDLE on an accepted word write or on no request.
- RESP→IDLE and MERGE→IDLE unconditionally.

Top module: `fbctl_regs`

## Requirements
- R1: After reset:
  - `bus_ready` is 1, and `bus_rvalid` and `irq` are 0.
  - Every table entry, the control word, the start offset, the cursor position, the width and the height read as 0.
- R2: A read of offset 0x000000 returns 0x00000010. A read is accepted when `bus_valid` is high while `bus_ready` is high. `bus_rvalid` is then 1 for exactly the next cycle, with the data on `bus_rdata`.
- R3: Colour table entry n is written and read at 0x080800 + 8n, or + 8n + 4, for n from 0 to 255. Red is in bits 23:16, green in 15:8 and blue in 7:0, and bits 31:24 read as 0. `pix_rgb` shows the entry selected by `pix_index`.
- R4: Cursor colour entry k (k = 0..2) is at 0x080508 + 8k and uses the same packing. `cur_rgb` shows entry `cur_sel`, and `cur_sel` = 3 gives 0.
- R5: Cursor bitmap entry m is at 0x081000 + 8m for m from 0 to 511. It keeps the low 16 bits written and reads back zero-extended. `pat_word` shows entry `pat_index`.
- R6: The control word at 0x080300 reads back as written. `force_blank` is its bit 10 and `cursor_off` is its bit 23.
- R7: Control bits 22:20 (codes 0..7) drive `pixel_depth` as 1, 2, 4, 8, 15, 16, 0 and 0 in that order. `depth_ok` is 1 only when the depth is 8.
- R8: `bus_size` 0 is a byte write. The byte comes from `bus_wdata[7:0]` and goes to lane (address mod 4), and the other three lanes of the current word are kept. Sizes 2 and 3 write the whole word.
- R9: `bus_size` 1 is a halfword write with the data in `bus_wdata[15:0]`. When address bit 1 is 1, it replaces bits 31:16 and keeps bits 15:0. When address bit 1 is 0, it replaces bits 15:0 and keeps bits 31:16.
- R10: Writes to the identifier, to 0x080000, to 0x080108 through 0x080200 other than the width and height registers, and to unmapped offsets change no state. Reads of those offsets other than the identifier return 0.
- R11: `frame_done` sets `irq` on the next edge. Every committed write clears it. When a write commits in the same cycle as `frame_done`, the write wins.
- R12: A word write commits on its accepting edge, and `bus_ready` is high again in the next cycle. A byte or halfword write holds `bus_ready` low for one cycle and commits on the following edge.
- R13: The following registers read back as written:
  - Cursor position at 0x080638, with `cursor_x` = bits 23:12 and `cursor_y` = bits 11:0.
  - Start offset at 0x080400, shown on `screen_top`.
  - Width at 0x080118, low 12 bits.
  - Height at 0x080150, low 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | 21 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| bus_ready | output | 1 | High when a request can be accepted |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| frame_done | input | 1 | One-cycle pulse at the end of each frame |
| irq | output | 1 | Frame interrupt |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry |
| cur_sel | input | 2 | Cursor colour lookup index |
| cur_rgb | output | 24 | Cursor colour entry |
| pat_index | input | 9 | Cursor bitmap lookup index |
| pat_word | output | 16 | Cursor bitmap entry |
| force_blank | output | 1 | Blank the screen |
| cursor_off | output | 1 | Hide the cursor |
| pixel_depth | output | 5 | Decoded bits per pixel |
| depth_ok | output | 1 | Depth is displayable (8) |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| screen_top | output | 32 | Scan-out start offset |
| disp_width | output | 12 | Display width |
| disp_height | output | 12 | Display height |

## Verification
The hardest case to reach is a sub-word write whose merge depends on the old word. The byte or halfword must land on top of a known non-zero value, in a table entry or in the control word, and the lanes kept from that value must be visible afterwards. The stimulus first loads full words with distinct patterns into each lane. It then issues byte writes to all four lanes and halfword writes to both halves, and reads back after each one. A second hard case is a write that commits on the same edge as a `frame_done` pulse. It is reached by raising both inputs on one negative edge.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_PAL, RG_CPAL, RG_PAT,
        RG_CTRL, RG_TOP, RG_CPOS, RG_WIDTH, RG_HEIGHT
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE, S_RESP, S_MERGE
    } seq_state_e;

    localparam logic [31:0] CHIP_ID = 32'h0000_0010;

    // merge right-aligned sub-word data into the current word
    function automatic logic [31:0] lane_merge(
        input logic [31:0] old_w,
        input logic [31:0] new_w,
        input logic [1:0]  sz,
        input logic [1:0]  lane
    );
        logic [31:0] r;
        r = new_w;
        case (sz)
            2'd0: begin
                case (lane)
                    2'd0: r = {old_w[31:8], new_w[7:0]};
                    2'd1: r = {old_w[31:16], new_w[7:0], old_w[7:0]};
                    2'd2: r = {old_w[31:24], new_w[7:0], old_w[15:0]};
                    default: r = {new_w[7:0], old_w[23:0]};
                endcase
            end
            2'd1: r = lane[1] ? {new_w[15:0], old_w[15:0]} : {old_w[31:16], new_w[15:0]};
            default: r = new_w;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] depth_lookup(input logic [2:0] code);
        logic [4:0] d;
        case (code)
            3'd0: d = 5'd1;
            3'd1: d = 5'd2;
            3'd2: d = 5'd4;
            3'd3: d = 5'd8;
            3'd4: d = 5'd15;
            3'd5: d = 5'd16;
            default: d = 5'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int IDX_W  = 9,
    parameter int PAL_N  = 256,
    parameter int CPAL_N = 3,
    parameter int PAT_N  = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rg,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] PAL_LO  = ADDR_W'(32'h0008_0800);
    localparam logic [ADDR_W-1:0] PAL_HI  = PAL_LO + ADDR_W'(PAL_N * 8);
    localparam logic [ADDR_W-1:0] CPAL_LO = ADDR_W'(32'h0008_0508);
    localparam logic [ADDR_W-1:0] CPAL_HI = CPAL_LO + ADDR_W'(CPAL_N * 8);
    localparam logic [ADDR_W-1:0] PAT_LO  = ADDR_W'(32'h0008_1000);
    localparam logic [ADDR_W-1:0] PAT_HI  = PAT_LO + ADDR_W'(PAT_N * 8);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(32'h0008_0300);
    localparam logic [ADDR_W-1:0] TOP_A   = ADDR_W'(32'h0008_0400);
    localparam logic [ADDR_W-1:0] CPOS_A  = ADDR_W'(32'h0008_0638);
    localparam logic [ADDR_W-1:0] WID_A   = ADDR_W'(32'h0008_0118);
    localparam logic [ADDR_W-1:0] HGT_A   = ADDR_W'(32'h0008_0150);

    logic [ADDR_W-1:0] wa;

    always_comb begin
        wa  = {addr[ADDR_W-1:2], 2'b00};
        rg  = RG_NONE;
        idx = '0;
        if (wa == '0) begin
            rg = RG_ID;
        end else if (wa >= PAL_LO && wa < PAL_HI) begin
            rg  = RG_PAL;
            idx = IDX_W'((wa - PAL_LO) >> 3);
        end else if (wa >= CPAL_LO && wa < CPAL_HI) begin
            rg  = RG_CPAL;
            idx = IDX_W'((wa - CPAL_LO) >> 3);
        end else if (wa >= PAT_LO && wa < PAT_HI) begin
            rg  = RG_PAT;
            idx = IDX_W'((wa - PAT_LO) >> 3);
        end else if (wa == CTRL_A) begin
            rg = RG_CTRL;
        end else if (wa == TOP_A) begin
            rg = RG_TOP;
        end else if (wa == CPOS_A) begin
            rg = RG_CPOS;
        end else if (wa == WID_A) begin
            rg = RG_WIDTH;
        end else if (wa == HGT_A) begin
            rg = RG_HEIGHT;
        end
    end

endmodule

// File: rtl/fbctl_store.sv
module fbctl_store
    import fbctl_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int PAL_N  = 256,
    parameter int CPAL_N = 3,
    parameter int PAT_N  = 512,
    parameter int PAT_W  = 16,
    parameter int DIM_W  = 12,
    localparam int PAL_IW  = $clog2(PAL_N),
    localparam int CPAL_IW = $clog2(CPAL_N),
    localparam int PAT_IW  = $clog2(PAT_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  region_e            rg,
    input  logic [IDX_W-1:0]   idx,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_word,
    input  logic [PAL_IW-1:0]  pix_index,
    output logic [23:0]        pix_rgb,
    input  logic [CPAL_IW-1:0] cur_sel,
    output logic [23:0]        cur_rgb,
    input  logic [PAT_IW-1:0]  pat_index,
    output logic [PAT_W-1:0]   pat_word,
    output logic [31:0]        ctrl_q,
    output logic [31:0]        top_q,
    output logic [31:0]        cpos_q,
    output logic [DIM_W-1:0]   width_q,
    output logic [DIM_W-1:0]   height_q
);
    localparam logic [CPAL_IW-1:0] CPAL_LAST = CPAL_IW'(CPAL_N - 1);

    logic [23:0]      pal_m  [PAL_N];
    logic [23:0]      cpal_m [CPAL_N];
    logic [PAT_W-1:0] pat_m  [PAT_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_N; i++)  pal_m[i]  <= '0;
            for (int i = 0; i < CPAL_N; i++) cpal_m[i] <= '0;
            for (int i = 0; i < PAT_N; i++)  pat_m[i]  <= '0;
            ctrl_q   <= '0;
            top_q    <= '0;
            cpos_q   <= '0;
            width_q  <= '0;
            height_q <= '0;
        end else if (we) begin
            case (rg)
                RG_PAL:    pal_m[idx[PAL_IW-1:0]]   <= wr_data[23:0];
                RG_CPAL:   cpal_m[idx[CPAL_IW-1:0]] <= wr_data[23:0];
                RG_PAT:    pat_m[idx[PAT_IW-1:0]]   <= wr_data[PAT_W-1:0];
                RG_CTRL:   ctrl_q   <= wr_data;
                RG_TOP:    top_q    <= wr_data;
                RG_CPOS:   cpos_q   <= wr_data;
                RG_WIDTH:  width_q  <= wr_data[DIM_W-1:0];
                RG_HEIGHT: height_q <= wr_data[DIM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rg)
            RG_ID:     rd_word = CHIP_ID;
            RG_PAL:    rd_word = {8'h00, pal_m[idx[PAL_IW-1:0]]};
            RG_CPAL:   rd_word = {8'h00, cpal_m[idx[CPAL_IW-1:0]]};
            RG_PAT:    rd_word = 32'(pat_m[idx[PAT_IW-1:0]]);
            RG_CTRL:   rd_word = ctrl_q;
            RG_TOP:    rd_word = top_q;
            RG_CPOS:   rd_word = cpos_q;
            RG_WIDTH:  rd_word = 32'(width_q);
            RG_HEIGHT: rd_word = 32'(height_q);
            default:   rd_word = '0;
        endcase
    end

    assign pix_rgb  = pal_m[pix_index];
    assign cur_rgb  = (cur_sel <= CPAL_LAST) ? cpal_m[cur_sel] : 24'h0;
    assign pat_word = pat_m[pat_index];

    // R6: a committed control write is visible on the next cycle
    a_r6_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rg == RG_CTRL) |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/fbctl_seq.sv
module fbctl_seq
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       rd_word,
    output logic [ADDR_W-1:0] look_addr,
    output logic              we,
    output logic [31:0]       wr_data
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [31:0]       data_q, old_q, rdata_q;
    logic              accept, sub_word;

    assign accept   = bus_valid && (state_q == S_IDLE);
    assign sub_word = !bus_size[1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept && !bus_write)
                    state_d = S_RESP;
                else if (accept && sub_word)
                    state_d = S_MERGE;
            end
            S_RESP:  state_d = S_IDLE;
            S_MERGE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            data_q  <= '0;
            old_q   <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= bus_addr;
            size_q  <= bus_size;
            data_q  <= bus_wdata;
            old_q   <= rd_word;
            rdata_q <= rd_word;
        end
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        we         = 1'b0;
        wr_data    = bus_wdata;
        look_addr  = addr_q;
        unique case (state_q)
            S_IDLE: begin
                bus_ready = 1'b1;
                look_addr = bus_addr;
                we        = accept && bus_write && !sub_word;
            end
            S_RESP: bus_rvalid = 1'b1;
            S_MERGE: begin
                we      = 1'b1;
                wr_data = lane_merge(old_q, data_q, size_q, addr_q[1:0]);
            end
            default: ;
        endcase
    end

    assign bus_rdata = rdata_q;

    // R12: sub-word write stalls one cycle and then commits
    a_r12_subword_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && !bus_size[1]) |=> (!bus_ready && we));

    // R12: a full-word write leaves the bus ready on the next cycle
    a_r12_word_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && bus_size[1]) |=> bus_ready);

    // R2: accepted read answers on the next cycle
    a_r2_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_write) |=> (bus_rvalid && !bus_ready));

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PAL_N  = 256,
    parameter int CPAL_N = 3,
    parameter int PAT_N  = 512,
    parameter int PAT_W  = 16,
    parameter int DIM_W  = 12,
    localparam int PAL_IW  = $clog2(PAL_N),
    localparam int CPAL_IW = $clog2(CPAL_N),
    localparam int PAT_IW  = $clog2(PAT_N),
    localparam int IDX_W   = (PAT_IW > PAL_IW) ? PAT_IW : PAL_IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [31:0]        bus_rdata,
    input  logic               frame_done,
    output logic               irq,
    input  logic [PAL_IW-1:0]  pix_index,
    output logic [23:0]        pix_rgb,
    input  logic [CPAL_IW-1:0] cur_sel,
    output logic [23:0]        cur_rgb,
    input  logic [PAT_IW-1:0]  pat_index,
    output logic [PAT_W-1:0]   pat_word,
    output logic               force_blank,
    output logic               cursor_off,
    output logic [4:0]         pixel_depth,
    output logic               depth_ok,
    output logic [11:0]        cursor_x,
    output logic [11:0]        cursor_y,
    output logic [31:0]        screen_top,
    output logic [DIM_W-1:0]   disp_width,
    output logic [DIM_W-1:0]   disp_height
);
    logic [ADDR_W-1:0] look_addr;
    region_e           rg;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       rd_word, wr_data, ctrl_q, cpos_q;
    logic              wr_en, irq_q;

    fbctl_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .rd_word(rd_word), .look_addr(look_addr), .we(wr_en), .wr_data(wr_data)
    );

    fbctl_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAL_N(PAL_N), .CPAL_N(CPAL_N), .PAT_N(PAT_N)
    ) u_dec (
        .addr(look_addr), .rg(rg), .idx(idx)
    );

    fbctl_store #(
        .IDX_W(IDX_W), .PAL_N(PAL_N), .CPAL_N(CPAL_N), .PAT_N(PAT_N),
        .PAT_W(PAT_W), .DIM_W(DIM_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .rg(rg), .idx(idx), .wr_data(wr_data), .rd_word(rd_word),
        .pix_index(pix_index), .pix_rgb(pix_rgb),
        .cur_sel(cur_sel), .cur_rgb(cur_rgb),
        .pat_index(pat_index), .pat_word(pat_word),
        .ctrl_q(ctrl_q), .top_q(screen_top), .cpos_q(cpos_q),
        .width_q(disp_width), .height_q(disp_height)
    );

    // a committed write lowers the line even when a frame ends together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (wr_en)      irq_q <= 1'b0;
        else if (frame_done) irq_q <= 1'b1;
    end

    assign irq         = irq_q;
    assign force_blank = ctrl_q[10];
    assign cursor_off  = ctrl_q[23];
    assign pixel_depth = depth_lookup(ctrl_q[22:20]);
    assign depth_ok    = (pixel_depth == 5'd8);
    assign cursor_x    = cpos_q[23:12];
    assign cursor_y    = cpos_q[11:0];

    // R11: writes clear the interrupt
    a_r11_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);

    // R11: frame end raises the interrupt when no write commits
    a_r11_frame_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !wr_en) |=> irq);

endmodule

// File: tb/fbctl_regs_tb_top.sv
`timescale 1ns/1ps
module fbctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        frame_done = 1'b0;
    logic        irq;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_rgb;
    logic [1:0]  cur_sel = '0;
    logic [23:0] cur_rgb;
    logic [8:0]  pat_index = '0;
    logic [15:0] pat_word;
    logic        force_blank, cursor_off, depth_ok;
    logic [4:0]  pixel_depth;
    logic [11:0] cursor_x, cursor_y, disp_width, disp_height;
    logic [31:0] screen_top;

    int checks = 0;
    int fails = 0;
    bit mon_en = 0;

    // behavioural model state
    int unsigned m_pal [256];
    int unsigned m_cpal [3];
    int unsigned m_pat [512];
    int unsigned m_ctrl = 0, m_top = 0, m_pos = 0, m_w = 0, m_h = 0;
    bit          m_irq = 0;

    always #10 clk = ~clk;

    fbctl_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .frame_done(frame_done), .irq(irq),
        .pix_index(pix_index), .pix_rgb(pix_rgb),
        .cur_sel(cur_sel), .cur_rgb(cur_rgb),
        .pat_index(pat_index), .pat_word(pat_word),
        .force_blank(force_blank), .cursor_off(cursor_off),
        .pixel_depth(pixel_depth), .depth_ok(depth_ok),
        .cursor_x(cursor_x), .cursor_y(cursor_y), .screen_top(screen_top),
        .disp_width(disp_width), .disp_height(disp_height)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned m_read(input logic [20:0] a);
        int unsigned w;
        w = {11'd0, a[20:2], 2'b00};
        if (w == 0) return 32'h10;
        if (w >= 32'h80800 && w < 32'h81000) return m_pal[(w - 32'h80800) / 8];
        if (w >= 32'h80508 && w < 32'h80520) return m_cpal[(w - 32'h80508) / 8];
        if (w >= 32'h81000 && w < 32'h82000) return m_pat[(w - 32'h81000) / 8];
        if (w == 32'h80300) return m_ctrl;
        if (w == 32'h80400) return m_top;
        if (w == 32'h80638) return m_pos;
        if (w == 32'h80118) return m_w;
        if (w == 32'h80150) return m_h;
        return 0;
    endfunction

    function automatic int unsigned depth_of(input int unsigned code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 15;
            5: return 16;
            default: return 0;
        endcase
    endfunction

    task automatic m_write(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
        int unsigned w, old, mask, val, sh;
        w = {11'd0, a[20:2], 2'b00};
        old = m_read(a);
        if (sz == 2'd0) begin
            sh = 8 * a[1:0];
            mask = 32'hFF << sh;
            val = (old & ~mask) | ((d & 32'hFF) << sh);
        end else if (sz == 2'd1) begin
            sh = a[1] ? 16 : 0;
            mask = 32'hFFFF << sh;
            val = (old & ~mask) | ((d & 32'hFFFF) << sh);
        end else begin
            val = d;
        end
        if (w >= 32'h80800 && w < 32'h81000) m_pal[(w - 32'h80800) / 8] = val & 32'hFFFFFF;
        else if (w >= 32'h80508 && w < 32'h80520) m_cpal[(w - 32'h80508) / 8] = val & 32'hFFFFFF;
        else if (w >= 32'h81000 && w < 32'h82000) m_pat[(w - 32'h81000) / 8] = val & 32'hFFFF;
        else if (w == 32'h80300) m_ctrl = val;
        else if (w == 32'h80400) m_top = val;
        else if (w == 32'h80638) m_pos = val;
        else if (w == 32'h80118) m_w = val & 32'hFFF;
        else if (w == 32'h80150) m_h = val & 32'hFFF;
        m_irq = 0;
    endtask

    task automatic do_write(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d,
                            input bit with_frame);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_size = sz; bus_addr = a; bus_wdata = d;
        frame_done = with_frame;
        @(posedge clk); #1;
        bus_valid = 0; frame_done = 0;
        if (sz[1] == 1'b0) begin
            chk("R12 stall after sub-word accept", {31'd0, bus_ready}, 32'd0);
            @(posedge clk); #1;
        end else begin
            chk("R12 ready after word write", {31'd0, bus_ready}, 32'd1);
        end
        m_write(a, sz, d);
    endtask

    task automatic do_read(input logic [20:0] a, input string tag);
        int unsigned exp;
        exp = m_read(a);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 0;
        chk({tag, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
        chk({tag, " rdata"}, bus_rdata, exp);
        @(posedge clk); #1;
        chk("R2 rvalid single cycle", {31'd0, bus_rvalid}, 32'd0);
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_done = 1;
        @(posedge clk); #1;
        frame_done = 0;
        m_irq = 1;
    endtask

    task automatic pix_check(input int pi, input int cs, input int ti, input string tag);
        @(negedge clk);
        pix_index = 8'(pi); cur_sel = 2'(cs); pat_index = 9'(ti);
        #1;
        chk({tag, " pix_rgb"}, {8'd0, pix_rgb}, m_pal[pi]);
        chk({tag, " cur_rgb"}, {8'd0, cur_rgb}, (cs < 3) ? m_cpal[cs] : 0);
        chk({tag, " pat_word"}, {16'd0, pat_word}, m_pat[ti]);
    endtask

    // per-cycle comparison of the exported fields against the model
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R6 force_blank", {31'd0, force_blank}, (m_ctrl >> 10) & 1);
            chk("R6 cursor_off", {31'd0, cursor_off}, (m_ctrl >> 23) & 1);
            chk("R7 pixel_depth", {27'd0, pixel_depth}, depth_of((m_ctrl >> 20) & 7));
            chk("R7 depth_ok", {31'd0, depth_ok}, (depth_of((m_ctrl >> 20) & 7) == 8) ? 1 : 0);
            chk("R13 cursor_x", {20'd0, cursor_x}, (m_pos >> 12) & 32'hFFF);
            chk("R13 cursor_y", {20'd0, cursor_y}, m_pos & 32'hFFF);
            chk("R13 screen_top", screen_top, m_top);
            chk("R13 width", {20'd0, disp_width}, m_w);
            chk("R13 height", {20'd0, disp_height}, m_h);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        foreach (m_pal[i]) m_pal[i] = 0;
        foreach (m_cpal[i]) m_cpal[i] = 0;
        foreach (m_pat[i]) m_pat[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, bus_ready}, 32'd1);
        chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        mon_en = 1;
        pix_check(0, 0, 0, "R1");
        pix_check(255, 2, 511, "R1");
        do_read(21'h080300, "R1 ctrl");

        // R2 identifier
        do_read(21'h000000, "R2 id");

        // R3 colour table
        do_write(21'h080800, 2'd2, 32'hFF123456, 0);
        do_write(21'h080FF8, 2'd2, 32'h00ABCDEF, 0);
        do_write(21'h08082C, 2'd2, 32'h00506070, 0);
        do_read(21'h080800, "R3 entry0");
        do_read(21'h080FF8, "R3 entry255");
        do_read(21'h080828, "R3 entry5");
        pix_check(0, 0, 0, "R3");
        pix_check(255, 0, 0, "R3");
        pix_check(5, 0, 0, "R3");

        // R4 cursor colours
        for (int k = 0; k < 3; k++)
            do_write(21'(32'h080508 + 8 * k), 2'd2, 32'h00111111 * (k + 1), 0);
        do_write(21'h080520, 2'd2, 32'h00777777, 0);
        do_read(21'h080510, "R4 entry1");
        do_read(21'h080520, "R10 past cursor table");
        for (int k = 0; k < 4; k++) pix_check(0, k, 0, "R4");

        // R5 cursor bitmap
        do_write(21'h081000, 2'd2, 32'hABCD1234, 0);
        do_write(21'h081FF8, 2'd3, 32'h0000BEEF, 0);
        do_read(21'h081000, "R5 entry0");
        do_read(21'h081FF8, "R5 entry511");
        pix_check(0, 0, 0, "R5");
        pix_check(0, 0, 511, "R5");

        // R6 R7 control word, every depth code
        for (int c = 0; c < 8; c++) begin
            do_write(21'h080300, 2'd2, (c << 20) | ((c & 1) << 10) | ((c & 2) << 22), 0);
            do_read(21'h080300, "R6 ctrl readback");
        end

        // R8 byte merge into control and colour table
        do_write(21'h080300, 2'd2, 32'h11223344, 0);
        for (int l = 0; l < 4; l++) begin
            do_write(21'(32'h080300 + l), 2'd0, 32'hFFFFFF00 | (8'hA0 + l), 0);
            do_read(21'h080300, "R8 byte lane");
        end
        do_write(21'h080807, 2'd0, 32'h000000EE, 0);
        do_write(21'h080806, 2'd0, 32'h0000007E, 0);
        do_read(21'h080800, "R8 byte into colour");

        // R9 halfword merge
        do_write(21'h080300, 2'd1, 32'hFFFF5A5A, 0);
        do_read(21'h080300, "R9 lower half");
        do_write(21'h080302, 2'd1, 32'h0000C3C3, 0);
        do_read(21'h080300, "R9 upper half");
        do_write(21'h081002, 2'd1, 32'h00009999, 0);
        do_read(21'h081000, "R9 upper half of bitmap");

        // R10 ignored writes, unmapped reads
        do_write(21'h000000, 2'd2, 32'hDEADBEEF, 0);
        do_write(21'h080000, 2'd2, 32'hDEADBEEF, 0);
        do_write(21'h080108, 2'd2, 32'hDEADBEEF, 0);
        do_write(21'h080200, 2'd2, 32'hDEADBEEF, 0);
        do_write(21'h100000, 2'd2, 32'hDEADBEEF, 0);
        do_read(21'h000000, "R10 id unchanged");
        do_read(21'h080300, "R10 ctrl unchanged");
        do_read(21'h080108, "R10 timing reads zero");
        do_read(21'h100000, "R10 unmapped reads zero");

        // R11 interrupt
        frame_pulse();
        do_write(21'h100000, 2'd2, 32'h0, 0);
        frame_pulse();
        frame_pulse();
        do_write(21'h080400, 2'd2, 32'h00012340, 1);
        frame_pulse();
        do_write(21'h080301, 2'd0, 32'h00000004, 0);

        // R13 position, offset, dimensions
        do_write(21'h080638, 2'd2, 32'h00ABC123, 0);
        do_write(21'h080400, 2'd2, 32'h87654320, 0);
        do_write(21'h080118, 2'd2, 32'h00001280, 0);
        do_write(21'h080150, 2'd2, 32'h000003FF, 0);
        do_read(21'h080638, "R13 cursor position");
        do_read(21'h080400, "R13 start offset");
        do_read(21'h080118, "R13 width");
        do_read(21'h080150, "R13 height");

        repeat (3) @(negedge clk);
        mon_en = 0;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule